// File: doc/BRIEF.md
# Charger Protection Fault Manager

This block supervises the protection comparators of a switched-capacitor battery charger. Each comparator delivers a one-bit raw flag. The block synchronizes each flag and filters it for a minimum width. It arms the flag only in the operating states where that check applies, and applies per-event disable controls to produce a qualified event vector. From that vector the block drives three things: live status bits, sticky flag bits that the host clears with a read pulse, and an active-low interrupt pulse of fixed width.

Fault-class events stop the converter through a level shutdown command. Over-voltage, over-current, reverse-current and over-temperature faults also force the internal charge-enable bit to 0 and emit a one-cycle clear strobe. The host must then rewrite charge-enable and run the start-up sequence again. Alarm-class events only report; they never stop switching. Mask bits only suppress the interrupt, and disable bits suppress reporting. The bus under-current event is the exception: disabling it removes only its shutdown effect.

Event indices (bit positions in every vector): 0 input OVP, 1 die-temperature alarm, 2 die-temperature fault, 3 output OVP, 4 bus thermistor fault, 5 battery thermistor fault, 6 bus OVP, 7 battery OVP, 8 bus OVP alarm, 9 bus OCP alarm, 10 battery OVP alarm, 11 battery OCP alarm, 12 battery UCP alarm, 13 battery OCP, 14 bus OCP, 15 bus UCP, 16 bus RCP. Operating state encoding: 0 battery only, 1 input present with charging off, 2 soft-start running, 3 soft-start done.

Top module: `pfm_top`

## Requirements
- R1: No event is armed in state 0. Events 0 to 7 are armed in states 1, 2 and 3. Events 8 to 14 and 16 are armed in states 2 and 3. Event 15 is armed only in state 3. An unarmed raw flag changes no output.
- R2: A raw flag counts as an event only after two synchronizer stages and DG_CYC further consecutive sampled-high cycles. A raw pulse of DG_CYC-1 clock cycles is ignored, and a pulse of DG_CYC cycles is accepted.
- R3: `stat[i]` is high exactly while event i is qualified (armed, filtered, not held by disable) and returns low when the raw flag drops.
- R4: `flags[i]` sets on the rising edge of qualified event i and stays set until `flag_rd` is pulsed. A new set in the same cycle as the read wins over the read.
- R5: A set `evt_mask[i]` leaves `stat[i]` and `flags[i]` working but stops event i from starting an interrupt pulse.
- R6: For every event other than 15, a set `evt_dis[i]` holds `stat[i]` and `flags[i]` at 0 and blocks its interrupt and shutdown effect.
- R7: With `evt_dis[15]` set, event 15 still sets `stat[15]` and `flags[15]` and raises the interrupt, but does not assert `conv_off`.
- R8: `int_n` goes low for exactly INT_W cycles (default 256) when an unmasked qualified event rises while no pulse is active. Rises during an active pulse are merged into it.
- R9: `conv_off` is high while any qualified, non-disabled fault-class event (0, 2 to 7, 13 to 16) is active. Alarm events (1, 8 to 12) never assert it.
- R10: A qualified fault among events 0, 2 to 7, 13, 14 and 16 clears `chg_en` and pulses `chg_en_clr` for one cycle. Event 15 and the alarms leave `chg_en` unchanged.
- R11: While a charge-enable-clearing fault is active, a host write to `chg_en` (including in the same cycle) is overridden and `chg_en` stays 0.
- R12: After reset `stat`, `flags`, `conv_off`, `chg_en` and `chg_en_clr` are 0 and `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_state | input | 2 | Operating state: 0 battery only, 1 input idle, 2 soft-start, 3 running |
| raw_evt | input | 17 | Raw comparator flags, one per event index |
| evt_mask | input | 17 | Per-event interrupt mask |
| evt_dis | input | 17 | Per-event protection disable |
| flag_rd | input | 1 | Host read pulse that clears the sticky flags |
| chg_wr | input | 1 | Host write strobe for the charge-enable bit |
| chg_wdata | input | 1 | Value written to charge-enable |
| stat | output | 17 | Live qualified event status |
| flags | output | 17 | Sticky event flags |
| int_n | output | 1 | Active-low interrupt pulse |
| conv_off | output | 1 | Converter shutdown command |
| chg_en | output | 1 | Charge-enable bit |
| chg_en_clr | output | 1 | One-cycle strobe when a fault clears charge-enable |

## Verification
The bench builds the block with DG_CYC = 3 and INT_W = 32. The short filter lets pulses of exactly DG_CYC-1 and DG_CYC cycles probe the acceptance boundary within a few clocks. The short interrupt pulse lets the bench count the full low width, and then place a second alarm inside one pulse to show that the two merge. It still leaves room for several separate pulses, each tied to a masked, disabled or under-current case, all within a short run.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int NEV = 17;

  typedef enum logic [1:0] {
    ST_BATT   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_SSTART = 2'd2,
    ST_RUN    = 2'd3
  } op_state_t;

  localparam int EV_BUS_UCP = 15;

  // arming groups by operating state
  localparam logic [NEV-1:0] ARM_PRESENT = 17'h000FF;
  localparam logic [NEV-1:0] ARM_CHARGE  = 17'h17F00;
  localparam logic [NEV-1:0] ARM_RUNNING = 17'h08000;

  // fault class stops switching, clear class also drops charge-enable
  localparam logic [NEV-1:0] FAULT_CLASS = 17'h1E0FD;
  localparam logic [NEV-1:0] CLEAR_CLASS = 17'h160FD;
  localparam logic [NEV-1:0] UCP_ONLY    = 17'h08000;

  function automatic logic [NEV-1:0] armed_vec(op_state_t s);
    logic [NEV-1:0] v;
    case (s)
      ST_IDLE:   v = ARM_PRESENT;
      ST_SSTART: v = ARM_PRESENT | ARM_CHARGE;
      ST_RUN:    v = ARM_PRESENT | ARM_CHARGE | ARM_RUNNING;
      default:   v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pfm_deglitch.sv
module pfm_deglitch #(
  parameter int DG_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic evt_o
);
  localparam int CW = $clog2(DG_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DG_CYC);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!s2_q)               cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + CW'(1);
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
    end
  end

  assign evt_o = (cnt_q == CNT_TOP);

  // R2: an accepted event only appears while the synchronized flag is high
  a_r2_rise_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_o) |-> $past(s2_q));
endmodule

// File: rtl/pfm_flag_int.sv
module pfm_flag_int #(
  parameter int NEV   = 17,
  parameter int INT_W = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] qual_i,
  input  logic [NEV-1:0] hold_i,
  input  logic [NEV-1:0] mask_i,
  input  logic           rd_i,
  output logic [NEV-1:0] flags_o,
  output logic           int_n_o
);
  localparam int TW = $clog2(INT_W + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(INT_W);

  logic [NEV-1:0] qual_dq, flags_q, flags_d, rise;
  logic [TW-1:0]  tmr_q, tmr_d;
  logic           new_ev, active;

  assign rise   = qual_i & ~qual_dq;
  assign new_ev = |(rise & ~mask_i);
  assign active = (tmr_q != '0);

  always_comb begin
    flags_d = ((flags_q & ~{NEV{rd_i}}) | rise) & ~hold_i;
  end

  always_comb begin
    if (active)      tmr_d = tmr_q - TW'(1);
    else if (new_ev) tmr_d = T_LOAD;
    else             tmr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_dq <= '0;
      flags_q <= '0;
      tmr_q   <= '0;
    end else begin
      qual_dq <= qual_i;
      flags_q <= flags_d;
      tmr_q   <= tmr_d;
    end
  end

  assign flags_o = flags_q;
  assign int_n_o = ~active;

  // R4: a set flag survives any cycle without a read or a disable hold
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~hold_i) != '0) && !rd_i |=> ((flags_q & $past(flags_q & ~hold_i)) == $past(flags_q & ~hold_i)));

  // R5: a pulse only starts after an unmasked rising event
  a_r5_int_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n_o) |-> $past(|(rise & ~mask_i)));

  // R8: the pulse lasts longer than one cycle
  a_r8_int_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n_o) |=> !int_n_o);

  // R6: a held event carries no flag after the edge
  a_r6_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(hold_i)) == '0));
endmodule

// File: rtl/pfm_top.sv
module pfm_top
  import pfm_pkg::*;
#(
  parameter int DG_CYC = 4,
  parameter int INT_W  = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     op_state,
  input  logic [NEV-1:0] raw_evt,
  input  logic [NEV-1:0] evt_mask,
  input  logic [NEV-1:0] evt_dis,
  input  logic           flag_rd,
  input  logic           chg_wr,
  input  logic           chg_wdata,
  output logic [NEV-1:0] stat,
  output logic [NEV-1:0] flags,
  output logic           int_n,
  output logic           conv_off,
  output logic           chg_en,
  output logic           chg_en_clr
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // per-event synchronizer and width filter
  logic [NEV-1:0] dg_evt;
  for (genvar g = 0; g < NEV; g++) begin : g_chan
    pfm_deglitch #(.DG_CYC(DG_CYC)) u_dg (
      .clk   (clk),
      .rst_n (rst_i),
      .raw_i (raw_evt[g]),
      .evt_o (dg_evt[g])
    );
  end

  // qualification by operating state and disable
  logic [NEV-1:0] armed, hold, qual, shut_src;
  logic           clr_src;

  assign armed    = armed_vec(op_state_t'(op_state));
  assign hold     = evt_dis & ~UCP_ONLY;
  assign qual     = dg_evt & armed & ~hold;
  assign shut_src = qual & FAULT_CLASS & ~evt_dis;
  assign clr_src  = |(qual & CLEAR_CLASS);
  assign stat     = qual;

  pfm_flag_int #(.NEV(NEV), .INT_W(INT_W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_i),
    .qual_i  (qual),
    .hold_i  (hold),
    .mask_i  (evt_mask),
    .rd_i    (flag_rd),
    .flags_o (flags),
    .int_n_o (int_n)
  );

  // shutdown and charge-enable
  logic off_q, off_d, en_q, en_d, clr_dq, stb_q, stb_d;

  always_comb begin
    off_d = |shut_src;
    if (clr_src)     en_d = 1'b0;
    else if (chg_wr) en_d = chg_wdata;
    else             en_d = en_q;
    stb_d = clr_src & ~clr_dq;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      off_q  <= 1'b0;
      en_q   <= 1'b0;
      clr_dq <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      off_q  <= off_d;
      en_q   <= en_d;
      clr_dq <= clr_src;
      stb_q  <= stb_d;
    end
  end

  assign conv_off   = off_q;
  assign chg_en     = en_q;
  assign chg_en_clr = stb_q;

  // R11: an active clearing fault overrides any host write
  a_r11_fault_wins: assert property (@(posedge clk) disable iff (!rst_i)
    clr_src |=> !chg_en);

  // R9: shutdown only follows a non-disabled fault-class event
  a_r9_shdn_cause: assert property (@(posedge clk) disable iff (!rst_i)
    conv_off |-> $past(|(dg_evt & armed & FAULT_CLASS & ~evt_dis)));

  // R10: the clear strobe is a single cycle and charge-enable is low with it
  a_r10_clr_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    chg_en_clr |-> !chg_en ##1 !chg_en_clr);

  // R7: a disabled under-current event never stops the converter alone
  a_r7_ucp_no_stop: assert property (@(posedge clk) disable iff (!rst_i)
    (evt_dis[EV_BUS_UCP] && ((shut_src & ~UCP_ONLY) == '0)) |=> !conv_off);
endmodule

// File: tb/pfm_top_test.sv
`timescale 1ns/1ps
module pfm_top_test;
  import pfm_pkg::*;

  localparam int DG = 3;
  localparam int IW = 32;

  logic           clk;
  logic           rst_n;
  logic [1:0]     op_state;
  logic [NEV-1:0] raw_evt, evt_mask, evt_dis;
  logic           flag_rd, chg_wr, chg_wdata;
  logic [NEV-1:0] stat, flags;
  logic           int_n, conv_off, chg_en, chg_en_clr;

  pfm_top #(.DG_CYC(DG), .INT_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .raw_evt(raw_evt),
    .evt_mask(evt_mask), .evt_dis(evt_dis), .flag_rd(flag_rd),
    .chg_wr(chg_wr), .chg_wdata(chg_wdata), .stat(stat), .flags(flags),
    .int_n(int_n), .conv_off(conv_off), .chg_en(chg_en), .chg_en_clr(chg_en_clr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int ilow   = 0;
  int nclr   = 0;
  bit done   = 0;

  typedef struct {
    string          tag;
    logic [NEV-1:0] st;
    logic [NEV-1:0] fl;
    bit             icare;
    logic           ie;
    logic           sd;
    logic           ce;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected snapshots and compares away from the edge
  always @(negedge clk) begin
    if (!int_n) ilow++;
    if (chg_en_clr) nclr++;
    if (sb.size() != 0) begin
      mon_e = sb.pop_front();
      chk(mon_e.tag, "stat", 32'(stat), 32'(mon_e.st));
      chk(mon_e.tag, "flags", 32'(flags), 32'(mon_e.fl));
      if (mon_e.icare) chk(mon_e.tag, "int_n", 32'(int_n), 32'(mon_e.ie));
      chk(mon_e.tag, "conv_off", 32'(conv_off), 32'(mon_e.sd));
      chk(mon_e.tag, "chg_en", 32'(chg_en), 32'(mon_e.ce));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_st(string tag, logic [NEV-1:0] st, logic [NEV-1:0] fl,
                           bit icare, logic ie, logic sd, logic ce);
    exp_t e;
    e.tag = tag; e.st = st; e.fl = fl; e.icare = icare; e.ie = ie; e.sd = sd; e.ce = ce;
    sb.push_back(e);
    tick(2);
  endtask

  task automatic pulse_raw(int idx, int len);
    @(negedge clk);
    raw_evt[idx] = 1'b1;
    repeat (len) @(negedge clk);
    raw_evt[idx] = 1'b0;
  endtask

  task automatic read_flags();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic host_write(logic v);
    @(negedge clk); chg_wr = 1'b1; chg_wdata = v;
    @(negedge clk); chg_wr = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [NEV-1:0] b(int i);
    return NEV'(1) << i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    int i0, c0;
    rst_n = 1'b0; op_state = 2'd0; raw_evt = '0; evt_mask = '0; evt_dis = '0;
    flag_rd = 1'b0; chg_wr = 1'b0; chg_wdata = 1'b0;
    tick(3);
    expect_st("R12 reset", '0, '0, 1, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    tick(4);
    expect_st("R12 after release", '0, '0, 1, 1'b1, 1'b0, 1'b0);

    host_write(1'b1);
    expect_st("R11 host write", '0, '0, 1, 1'b1, 1'b0, 1'b1);

    // R1: arming by state
    op_state = 2'd0; raw_evt[6] = 1'b1; tick(8);
    expect_st("R1 state0 bus ovp", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    raw_evt[6] = 1'b0; tick(5);
    op_state = 2'd1; raw_evt[12] = 1'b1; tick(8);
    expect_st("R1 state1 alarm", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    raw_evt[12] = 1'b0; tick(5);
    op_state = 2'd2; raw_evt[15] = 1'b1; tick(8);
    expect_st("R1 state2 ucp", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    raw_evt[15] = 1'b0; tick(5);
    raw_evt[12] = 1'b1; tick(8);
    expect_st("R1 state2 alarm armed", b(12), b(12), 1, 1'b0, 1'b0, 1'b1);
    raw_evt[12] = 1'b0; tick(40);
    read_flags();

    // R2: filter boundary
    op_state = 2'd3;
    pulse_raw(1, DG - 1); tick(8);
    expect_st("R2 short pulse", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    i0 = ilow;
    pulse_raw(1, DG); tick(4);
    expect_st("R2 exact pulse", '0, b(1), 1, 1'b0, 1'b0, 1'b1);
    tick(50);
    chk("R8 pulse width", "low cycles", 32'(ilow - i0), 32'(IW));
    read_flags();
    expect_st("R4 read clears", '0, '0, 1, 1'b1, 1'b0, 1'b1);

    // R5 / R3: masked alarm
    evt_mask[9] = 1'b1; raw_evt[9] = 1'b1; tick(DG + 5);
    expect_st("R5 masked live", b(9), b(9), 1, 1'b1, 1'b0, 1'b1);
    raw_evt[9] = 1'b0; tick(4);
    expect_st("R3 stat drops flag stays", '0, b(9), 1, 1'b1, 1'b0, 1'b1);
    read_flags(); evt_mask = '0;

    // R6: disabled alarm and fault
    evt_dis[10] = 1'b1; raw_evt[10] = 1'b1; tick(8);
    expect_st("R6 disabled alarm", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    raw_evt[10] = 1'b0;
    evt_dis[7] = 1'b1; raw_evt[7] = 1'b1; tick(8);
    expect_st("R6 disabled fault", '0, '0, 1, 1'b1, 1'b0, 1'b1);
    raw_evt[7] = 1'b0; tick(DG + 4);
    evt_dis = '0; tick(2);

    // R7: disabled under-current
    evt_dis[15] = 1'b1; raw_evt[15] = 1'b1; tick(8);
    expect_st("R7 ucp disabled", b(15), b(15), 1, 1'b0, 1'b0, 1'b1);
    raw_evt[15] = 1'b0; tick(40);
    read_flags(); evt_dis = '0; tick(2);

    // R9 / R10: under-current stops but keeps charge-enable
    raw_evt[15] = 1'b1; tick(8);
    expect_st("R9 ucp stops", b(15), b(15), 1, 1'b0, 1'b1, 1'b1);
    raw_evt[15] = 1'b0; tick(5);
    expect_st("R9 ucp released", '0, b(15), 0, 1'b0, 1'b0, 1'b1);
    tick(40); read_flags();

    // R10 / R11: clearing fault
    c0 = nclr;
    raw_evt[14] = 1'b1; tick(8);
    expect_st("R10 ocp clears", b(14), b(14), 1, 1'b0, 1'b1, 1'b0);
    host_write(1'b1); tick(1);
    expect_st("R11 write overridden", b(14), b(14), 0, 1'b0, 1'b1, 1'b0);
    raw_evt[14] = 1'b0; tick(6);
    expect_st("R10 stays cleared", '0, b(14), 0, 1'b0, 1'b0, 1'b0);
    host_write(1'b1);
    expect_st("R11 rewrite after fault", '0, b(14), 0, 1'b0, 1'b0, 1'b1);
    chk("R10 strobe", "cycles", 32'(nclr - c0), 32'd1);
    tick(40); read_flags();

    // R8: merge of two alarms into one pulse
    i0 = ilow;
    raw_evt[11] = 1'b1; tick(5);
    raw_evt[12] = 1'b1; tick(6);
    raw_evt[11] = 1'b0; raw_evt[12] = 1'b0; tick(60);
    expect_st("R8 merged flags", '0, b(11) | b(12), 1, 1'b1, 1'b0, 1'b1);
    chk("R8 merged pulse", "low cycles", 32'(ilow - i0), 32'(IW));
    chk("R10 no extra strobe", "cycles", 32'(nclr - c0), 32'd1);

    done = 1;
    report();
    $finish;
  end
endmodule